// File: doc/BRIEF.md
# Boundary Scan Data Register Chain

This block is the boundary scan data register of a programmable-logic device with a parameterised number of bidirectional I/O blocks, plus a few input-only and output-only pins. Each bidirectional I/O owns three scan cells: pad input, output value and output enable. An input-only pin owns only an input cell, and an output-only pin owns only an output cell. Pins used only for device configuration have no cells. The chain also holds non-pin test bits. Two sit at the scan-out end and one sits at the scan-in end.

The block sits between the TAP controller and the pad ring. It receives the TAP's capture, shift and update strobes and the decoded instruction, which is either external test or sample/preload. Every cell has a capture/shift flop that moves on the rising test clock. Output and enable cells also have an update flop, which loads on the falling test clock. While the external test instruction is active, those update flops drive the pads. Otherwise the pads carry the core's values.

Top module: `bscan_chain`

## Requirements
- R1: The chain length is L = 3*NUM_IO + NUM_IN_ONLY + NUM_OUT_ONLY + 3. Bit 0 is the scan-out enable test bit and bit 1 is the scan-out data test bit. I/O i uses bit 2+3i for its input cell, 3+3i for its output cell and 4+3i for its enable cell. Input-only pins follow, then output-only pins. Bit L-1 is the end marker. On capture, bits 0 and 1 load 0 and bit L-1 loads 1.
- R2: On each rising tck with shift_dr high and either instruction selected, every bit k loads bit k+1 and bit L-1 loads tdi. The tdo output shows bit 0, so the first tdi bit shifted in ends up in bit 0 after L shifts.
- R3: On a rising tck with capture_dr high and either instruction selected, all cells load their pin-side values at once. Input cells load pad_in or inonly_pad, output cells load core_out or outonly_core, and enable cells load core_oe.
- R4: Update flops load their capture/shift bit on the falling tck while update_dr is high and an instruction is selected. At all other times they hold, so shifting never changes the values driven to the pads.
- R5: While sel_extest is high, pad_out, pad_oe and outonly_pad come from the update flops. While it is low, they equal core_out, core_oe and outonly_core.
- R6: While trst_n is low, all capture/shift and update flops are cleared. With sel_extest high this gives pad_oe = 0 and pad_out = 0, and tdo = 0.
- R7: When neither sel_extest nor sel_sample is high, the capture, shift and update strobes are ignored and the chain contents are kept.
- R8: Under sel_sample, capture and update operate but the pads keep core values. Values updated this way appear on the pads as soon as sel_extest is raised.
- R9: An input-only pin has a single capture cell with no update flop. An output-only pin has a single cell whose update flop drives outonly_pad under sel_extest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| capture_dr | input | 1 | TAP is in capture-DR |
| shift_dr | input | 1 | TAP is in shift-DR |
| update_dr | input | 1 | TAP is in update-DR |
| sel_extest | input | 1 | External test instruction decoded |
| sel_sample | input | 1 | Sample/preload instruction decoded |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (chain bit 0) |
| pad_in | input | NUM_IO | Values seen at the bidirectional pads |
| core_out | input | NUM_IO | Core output values |
| core_oe | input | NUM_IO | Core output enables |
| pad_out | output | NUM_IO | Output value sent to the pads |
| pad_oe | output | NUM_IO | Output enable sent to the pads |
| inonly_pad | input | NUM_IN_ONLY | Input-only pad values |
| outonly_core | input | NUM_OUT_ONLY | Core values for output-only pins |
| outonly_pad | output | NUM_OUT_ONLY | Values driven to output-only pads |

## Verification
The embedded properties check four things on every clock. A capture loads exactly the pin-side values. A shift moves every bit one place toward scan-out. The update flops hold unless the update strobe is present. With no instruction selected, the chain is frozen. The bench scenarios cover the rest. They check the exact bit layout and the end-marker values of captured words, and they check that pads carry core values outside external test. They also show that values preloaded under sample appear once external test begins, that a full shift under external test leaves the pads untouched until update, and that reset turns the enables off.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Cell offsets inside one bidirectional I/O group
  localparam int OFS_IN  = 0;
  localparam int OFS_OUT = 1;
  localparam int OFS_OE  = 2;

  // Number of fixed non-pin bits at the scan-out end
  localparam int HEAD_BITS = 2;

  function automatic int chain_len(input int nio, input int nin, input int nout);
    return HEAD_BITS + 3 * nio + nin + nout + 1;
  endfunction

  function automatic int io_pos(input int i, input int ofs);
    return HEAD_BITS + 3 * i + ofs;
  endfunction

  function automatic int in_only_pos(input int nio, input int j);
    return HEAD_BITS + 3 * nio + j;
  endfunction

  function automatic int out_only_pos(input int nio, input int nin, input int k);
    return HEAD_BITS + 3 * nio + nin + k;
  endfunction

endpackage

// File: rtl/bscan_ctl.sv
module bscan_ctl (
  input  logic tck,
  input  logic trst_n,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic sel_extest,
  input  logic sel_sample,
  output logic cap_en,
  output logic shf_en,
  output logic upd_en,
  output logic drive_pads
);

  logic chain_selected;

  assign chain_selected = sel_extest | sel_sample;
  assign cap_en         = chain_selected & capture_dr;
  assign shf_en         = chain_selected & shift_dr & ~capture_dr;
  assign upd_en         = chain_selected & update_dr;
  assign drive_pads     = sel_extest;

  // The TAP never asserts two DR strobes at once
  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({cap_en, shf_en, upd_en})); // R2

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic cap_val,
  input  logic ser_in,
  output logic sh_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     sh_q <= 1'b0;
    else if (cap_en) sh_q <= cap_val;
    else if (shf_en) sh_q <= ser_in;
  end

  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> (sh_q == $past(cap_val))); // R3

endmodule

// File: rtl/bscan_upd.sv
module bscan_upd (
  input  logic tck,
  input  logic trst_n,
  input  logic upd_en,
  input  logic d,
  output logic q
);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     q <= 1'b0;
    else if (upd_en) q <= d;
  end

  AST_UPDATE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_en |-> $stable(q)); // R4

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int NUM_IO       = 4,
  parameter int NUM_IN_ONLY  = 1,
  parameter int NUM_OUT_ONLY = 1
) (
  input  logic                    tck,
  input  logic                    trst_n,
  input  logic                    capture_dr,
  input  logic                    shift_dr,
  input  logic                    update_dr,
  input  logic                    sel_extest,
  input  logic                    sel_sample,
  input  logic                    tdi,
  output logic                    tdo,
  input  logic [NUM_IO-1:0]       pad_in,
  input  logic [NUM_IO-1:0]       core_out,
  input  logic [NUM_IO-1:0]       core_oe,
  output logic [NUM_IO-1:0]       pad_out,
  output logic [NUM_IO-1:0]       pad_oe,
  input  logic [NUM_IN_ONLY-1:0]  inonly_pad,
  input  logic [NUM_OUT_ONLY-1:0] outonly_core,
  output logic [NUM_OUT_ONLY-1:0] outonly_pad
);
  import bscan_pkg::*;

  localparam int L = chain_len(NUM_IO, NUM_IN_ONLY, NUM_OUT_ONLY);

  logic          cap_en, shf_en, upd_en, drive_pads;
  logic [L-1:0]  sh_q;
  logic [L-1:0]  cap_vec;
  logic [L-1:0]  ser_vec;
  logic [NUM_IO-1:0]       upd_out, upd_oe;
  logic [NUM_OUT_ONLY-1:0] upd_oo;

  bscan_ctl u_ctl (
    .tck        (tck),
    .trst_n     (trst_n),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .sel_extest (sel_extest),
    .sel_sample (sel_sample),
    .cap_en     (cap_en),
    .shf_en     (shf_en),
    .upd_en     (upd_en),
    .drive_pads (drive_pads)
  );

  // Pin-side capture values placed at their chain positions
  always_comb begin
    cap_vec        = '0;
    cap_vec[L-1]   = 1'b1;   // end marker
    for (int i = 0; i < NUM_IO; i++) begin
      cap_vec[io_pos(i, OFS_IN)]  = pad_in[i];
      cap_vec[io_pos(i, OFS_OUT)] = core_out[i];
      cap_vec[io_pos(i, OFS_OE)]  = core_oe[i];
    end
    for (int j = 0; j < NUM_IN_ONLY; j++)
      cap_vec[in_only_pos(NUM_IO, j)] = inonly_pad[j];
    for (int k = 0; k < NUM_OUT_ONLY; k++)
      cap_vec[out_only_pos(NUM_IO, NUM_IN_ONLY, k)] = outonly_core[k];
  end

  assign ser_vec = {tdi, sh_q[L-1:1]};

  for (genvar b = 0; b < L; b++) begin : g_cell
    bscan_cell u_cell (
      .tck     (tck),
      .trst_n  (trst_n),
      .cap_en  (cap_en),
      .shf_en  (shf_en),
      .cap_val (cap_vec[b]),
      .ser_in  (ser_vec[b]),
      .sh_q    (sh_q[b])
    );
  end

  for (genvar i = 0; i < NUM_IO; i++) begin : g_io_upd
    bscan_upd u_out (
      .tck (tck), .trst_n (trst_n), .upd_en (upd_en),
      .d   (sh_q[io_pos(i, OFS_OUT)]), .q (upd_out[i])
    );
    bscan_upd u_oe (
      .tck (tck), .trst_n (trst_n), .upd_en (upd_en),
      .d   (sh_q[io_pos(i, OFS_OE)]), .q (upd_oe[i])
    );
  end

  for (genvar k = 0; k < NUM_OUT_ONLY; k++) begin : g_oo_upd
    bscan_upd u_oo (
      .tck (tck), .trst_n (trst_n), .upd_en (upd_en),
      .d   (sh_q[out_only_pos(NUM_IO, NUM_IN_ONLY, k)]), .q (upd_oo[k])
    );
  end

  assign pad_out     = drive_pads ? upd_out : core_out;
  assign pad_oe      = drive_pads ? upd_oe  : core_oe;
  assign outonly_pad = drive_pads ? upd_oo  : outonly_core;
  assign tdo         = sh_q[0];

  AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!trst_n)
    shf_en |=> (sh_q[L-2:0] == $past(sh_q[L-1:1]))); // R2

  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel_extest || sel_sample) |=> $stable(sh_q)); // R7

endmodule

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;
  localparam int NIO  = 4;
  localparam int NIN  = 1;
  localparam int NOUT = 1;
  localparam int L    = 3 * NIO + NIN + NOUT + 3;
  localparam int VW   = 3 * NIO + NIN + NOUT;
  localparam int NVEC = 4;

  // {pad_in, core_out, core_oe, inonly_pad, outonly_core}
  localparam logic [VW-1:0] VECS [NVEC] = '{
    14'b1010_0110_1100_1_0,
    14'b0101_1001_0011_0_1,
    14'b1111_0000_1010_1_1,
    14'b0001_1110_0111_0_0
  };

  logic tck = 1'b0;
  always #4 tck = ~tck;   // 125 MHz

  logic trst_n, capture_dr, shift_dr, update_dr, sel_extest, sel_sample, tdi, tdo;
  logic [NIO-1:0]  pad_in, core_out, core_oe, pad_out, pad_oe;
  logic [NIN-1:0]  inonly_pad;
  logic [NOUT-1:0] outonly_core, outonly_pad;

  bscan_chain #(.NUM_IO(NIO), .NUM_IN_ONLY(NIN), .NUM_OUT_ONLY(NOUT)) dut (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .sel_extest(sel_extest), .sel_sample(sel_sample),
    .tdi(tdi), .tdo(tdo), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .inonly_pad(inonly_pad),
    .outonly_core(outonly_core), .outonly_pad(outonly_pad)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #2;
  endtask

  task automatic apply(input logic [VW-1:0] v);
    {pad_in, core_out, core_oe, inonly_pad, outonly_core} = v;
  endtask

  // Expected captured word, built by walking a position pointer
  function automatic logic [L-1:0] exp_cap(input logic [VW-1:0] v);
    logic [NIO-1:0] pi, co, ce;
    logic [NIN-1:0] io;
    logic [NOUT-1:0] oc;
    logic [L-1:0] r;
    int p;
    {pi, co, ce, io, oc} = v;
    r = '0;
    p = 2;
    for (int i = 0; i < NIO; i++) begin
      r[p] = pi[i]; r[p+1] = co[i]; r[p+2] = ce[i];
      p += 3;
    end
    for (int j = 0; j < NIN; j++) begin r[p] = io[j]; p++; end
    for (int k = 0; k < NOUT; k++) begin r[p] = oc[k]; p++; end
    r[p] = 1'b1;
    return r;
  endfunction

  function automatic logic [NIO-1:0] exp_out(input logic [L-1:0] w);
    logic [NIO-1:0] r;
    for (int i = 0; i < NIO; i++) r[i] = w[3 + 3 * i];
    return r;
  endfunction

  function automatic logic [NIO-1:0] exp_oe(input logic [L-1:0] w);
    logic [NIO-1:0] r;
    for (int i = 0; i < NIO; i++) r[i] = w[4 + 3 * i];
    return r;
  endfunction

  function automatic logic [NOUT-1:0] exp_oo(input logic [L-1:0] w);
    logic [NOUT-1:0] r;
    for (int k = 0; k < NOUT; k++) r[k] = w[2 + 3 * NIO + NIN + k];
    return r;
  endfunction

  task automatic scan(input bit cap, input logic [L-1:0] din, output logic [L-1:0] dout);
    if (cap) begin
      capture_dr = 1'b1; step(); capture_dr = 1'b0;
    end
    shift_dr = 1'b1;
    for (int k = 0; k < L; k++) begin
      dout[k] = tdo;
      tdi = din[k];
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic upd();
    update_dr = 1'b1; step(); update_dr = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  localparam logic [L-1:0] P1 = 17'h1A5C3;
  localparam logic [L-1:0] P2 = 17'h0B6D9;
  localparam logic [L-1:0] Q  = 17'h15A2E;

  initial begin
    logic [L-1:0] d;
    trst_n = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    sel_extest = 1'b1; sel_sample = 1'b0; tdi = 1'b0;
    pad_in = '0; core_out = '1; core_oe = '1; inonly_pad = '0; outonly_core = '1;
    repeat (3) step();
    chk("R6 reset pad_oe", 64'(pad_oe), 64'(0));
    chk("R6 reset pad_out", 64'(pad_out), 64'(0));
    chk("R6 reset tdo", 64'(tdo), 64'(0));
    sel_extest = 1'b0;
    trst_n = 1'b1;
    step();

    // Table walk: capture under sample, pads follow core
    sel_sample = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v]);
      scan(1'b1, '0, d);
      chk("R3/R9 captured word", 64'(d), 64'(exp_cap(VECS[v])));
      chk("R5 pads follow core", 64'({pad_out, pad_oe, outonly_pad}),
          64'({core_out, core_oe, outonly_core}));
      if (v == 0) begin
        chk("R1 head bits", 64'(d[1:0]), 64'(0));
        chk("R1 end marker", 64'(d[L-1]), 64'(1));
      end
    end

    // R2: shifted data emerges after exactly L shifts
    scan(1'b0, P1, d);
    scan(1'b0, P2, d);
    chk("R2 shift-through", 64'(d), 64'(P1));

    // R8: preload under sample, pads keep core values
    upd();
    chk("R8 sample keeps core", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
    sel_sample = 1'b0; sel_extest = 1'b1;
    #1;
    chk("R8 preload shows on extest", 64'({pad_out, pad_oe}),
        64'({exp_out(P2), exp_oe(P2)}));
    chk("R9 output-only preload", 64'(outonly_pad), 64'(exp_oo(P2)));

    // R4: shifting under extest leaves pads until update
    scan(1'b0, Q, d);
    chk("R2 chain held P2", 64'(d), 64'(P2));
    chk("R4 pads unchanged by shift", 64'({pad_out, pad_oe}),
        64'({exp_out(P2), exp_oe(P2)}));
    upd();
    chk("R4/R5 pads after update", 64'({pad_out, pad_oe}),
        64'({exp_out(Q), exp_oe(Q)}));
    chk("R9 output-only after update", 64'(outonly_pad), 64'(exp_oo(Q)));

    // R7: strobes ignored without an instruction
    sel_extest = 1'b0;
    apply(VECS[2]);
    capture_dr = 1'b1; step(); capture_dr = 1'b0;
    tdi = 1'b1;
    shift_dr = 1'b1; step(); step(); shift_dr = 1'b0;
    update_dr = 1'b1; step(); update_dr = 1'b0;
    sel_extest = 1'b1;
    #1;
    chk("R7 update ignored", 64'({pad_out, pad_oe}), 64'({exp_out(Q), exp_oe(Q)}));
    sel_extest = 1'b0; sel_sample = 1'b1;
    scan(1'b0, '0, d);
    chk("R7 chain kept", 64'(d), 64'(Q));

    // R6: reset during extest turns enables off
    sel_sample = 1'b0; sel_extest = 1'b1;
    trst_n = 1'b0;
    #1;
    chk("R6 reset clears enables", 64'(pad_oe), 64'(0));
    chk("R6 reset clears tdo", 64'(tdo), 64'(0));
    step();
    trst_n = 1'b1;
    step();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule